// File: doc/BRIEF.md
# Synchronous Serial Byte Transmitter with Ready Strobes

This block sends one byte at a time over a clocked serial link. A byte enters through a valid/ready write port and is shifted out on `sout`, least significant bit first. A new bit appears on every falling edge of the shift clock, so the partner can sample each bit on the following rising edge. The shift clock comes from one of two sources. It can be generated inside the block by dividing the system clock, in which case it appears on `sck_out`. It can also be taken from the partner on `sck_in`, which is passed through a two-stage synchronizer and edge-detected in the system clock domain.

Two complementary strobes let the partner see when a byte is pending:
- `rdy_n` drops when the byte is written and returns high at the first falling shift edge.
- `rdy` rises when the byte is written and falls at the rising edge that completes the eighth bit.

At completion the block sets a sticky interrupt flag, which stays set until `irq_clr` is pulsed. With the internal clock, the shift clock halts by itself after eight bits. With the external clock, every further falling edge keeps shifting the register, which fills with zeros from the top. Stopping after eight edges is left to the partner.

Write-port rules:
- A byte is taken only in a cycle where both `wr_valid` and `wr_ready` are high.
- `wr_ready` is high only while the block is not busy and `tx_en` is high.
- An offer made while `wr_ready` is low is dropped and has no effect. The source may withdraw it at any time.
- With the external clock, writes should be made while `sck_in` is high.

Top module: `ser_tx_port`

## Requirements
- R1: A write accepted at a clock edge makes `busy`=1, `rdy_n`=0 and `rdy`=1 visible after that edge, and loads the 3-bit bit counter with 7.
- R2: While `busy`=1 or `tx_en`=0, `wr_ready` is 0. An offered byte is then not taken and does not disturb the bits being sent.
- R3: With `ext_clk_sel`=0, `sck_out` rests high. After a write it toggles every CLK_DIV system clocks, so its first fall comes CLK_DIV cycles after the accepting edge. After exactly eight low phases it stays high.
- R4: Bits appear on `sout` least significant first. Each bit changes at a falling shift edge and is stable at the next rising edge.
- R5: `rdy_n` returns high at the first falling shift edge of the transfer.
- R6: With the internal clock, `irq`=1, `rdy`=0 and `busy`=0 all appear together 16×CLK_DIV cycles after the accepting edge, at the rising edge that follows the eighth fall. `wr_ready` returns to 1.
- R7: `irq` stays set until `irq_clr` is pulsed. If completion and `irq_clr` fall in the same cycle, completion wins and `irq` stays 1.
- R8: With `ext_clk_sel`=1, edges of `sck_in` take effect about three system clocks later. Falls shift bits out, and the rising edge after the eighth fall sets `irq`, clears `rdy` and `busy`. Later falls keep shifting and put out zeros.
- R9: While no shift edge occurs, `sout` holds the last bit driven.
- R10: After reset, `busy`=0, `irq`=0, `rdy_n`=1, `rdy`=0, `sck_out`=1, and `wr_ready` equals `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enabled; gates acceptance of writes |
| ext_clk_sel | input | 1 | 0: internal divided shift clock, 1: shift clock from `sck_in` |
| wr_valid | input | 1 | Write offer valid |
| wr_ready | output | 1 | Write can be taken (idle and enabled) |
| wr_data | input | DATA_W | Byte to send |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky transfer-complete flag |
| busy | output | 1 | Transfer in progress |
| sck_in | input | 1 | External shift clock from partner |
| sck_out | output | 1 | Internal shift clock, high when idle or in external mode |
| sout | output | 1 | Serial data out |
| rdy_n | output | 1 | Active-low byte-pending strobe |
| rdy | output | 1 | Active-high byte-pending strobe |

## Verification
The closest timing clash is between the completion edge, which sets `irq`, and a software `irq_clr` pulse. The bench times `irq_clr` to land exactly on the cycle 16×CLK_DIV after acceptance and expects `irq` to read 1 afterwards. A second coincidence is a write offered while a transfer is shifting. The bench offers a different byte in the middle of a transfer and expects `wr_ready` low. The scoreboard must then still see only the original eight bits.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic {
    SCK_INTERNAL = 1'b0,
    SCK_EXTERNAL = 1'b1
  } sck_src_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sck_evt_t;
endpackage

// File: rtl/sck_engine.sv
module sck_engine
  import ser_tx_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sck_src_e src_i,
  input  logic     run_i,
  input  logic     start_i,
  input  logic     sck_pin_i,
  output sck_evt_t evt_o,
  output logic     sck_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          sck_q;
  logic          tick;
  logic [SYNC_STAGES:0] chain_q;
  logic          ext_fall, ext_rise;

  generate
    if (CLK_DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      assign tick = run_i && (src_i == SCK_INTERNAL) && (div_q == DW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   div_q <= '0;
        else if (start_i || tick)                     div_q <= '0;
        else if (run_i && src_i == SCK_INTERNAL)      div_q <= div_q + 1'b1;
        else                                          div_q <= '0;
      end
    end else begin : g_nodiv
      assign tick = run_i && (src_i == SCK_INTERNAL);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sck_q <= 1'b1;
    else if (start_i) sck_q <= 1'b1;
    else if (tick)    sck_q <= ~sck_q;
    else if (!run_i || src_i != SCK_INTERNAL) sck_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], sck_pin_i};
  end

  assign ext_fall = (src_i == SCK_EXTERNAL) &&  chain_q[SYNC_STAGES] && !chain_q[SYNC_STAGES-1];
  assign ext_rise = (src_i == SCK_EXTERNAL) && !chain_q[SYNC_STAGES] &&  chain_q[SYNC_STAGES-1];

  assign evt_o.fall = tick ?  sck_q : ext_fall;
  assign evt_o.rise = tick ? !sck_q : ext_rise;
  assign sck_o      = (src_i == SCK_EXTERNAL) ? 1'b1 : sck_q;

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> sck_q);
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              sout_o
);
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      sout_o <= 1'b1;
    end else if (load_i) begin
      sreg_q <= data_i;
    end else if (shift_i) begin
      sout_o <= sreg_q[0];
      sreg_q <= {1'b0, sreg_q[DATA_W-1:1]};
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(sout_o));
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  sck_evt_t evt_i,
  input  logic     irq_clr_i,
  output logic     busy_o,
  output logic     irq_o,
  output logic     rdy_n_o,
  output logic     rdy_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q, last_q, irq_q, rdy_n_q, rdy_q;
  logic          done;

  assign done = busy_q && evt_i.rise && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      rdy_n_q <= 1'b1;
      rdy_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CW'(DATA_W - 1);
      busy_q  <= 1'b1;
      last_q  <= 1'b0;
      rdy_n_q <= 1'b0;
      rdy_q   <= 1'b1;
    end else if (busy_q) begin
      if (evt_i.fall) begin
        cnt_q   <= cnt_q - 1'b1;
        rdy_n_q <= 1'b1;
        if (cnt_q == '0) last_q <= 1'b1;
      end
      if (done) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
        rdy_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (done)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign busy_o  = busy_q;
  assign irq_o   = irq_q;
  assign rdy_n_o = rdy_n_q;
  assign rdy_o   = rdy_q;

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_q && !rdy_n_q && rdy_q && cnt_q == CW'(DATA_W - 1));
  // R1
  rdy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_q |-> rdy_q);
  // R5
  first_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && evt_i.fall && !start_i |=> rdy_n_q);
  // R6
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq_q && !rdy_q);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr_i |=> irq_q);
endmodule

// File: rtl/ser_tx_port.sv
module ser_tx_port
  import ser_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              ext_clk_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic              irq,
  output logic              busy,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sout,
  output logic              rdy_n,
  output logic              rdy
);
  sck_src_e src;
  sck_evt_t evt;
  logic     start, shift_en;

  assign src      = sck_src_e'(ext_clk_sel);
  assign wr_ready = tx_en && !busy;
  assign start    = wr_valid && wr_ready;
  assign shift_en = evt.fall && (busy || src == SCK_EXTERNAL);

  sck_engine #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_sck (
    .clk(clk), .rst_n(rst_n), .src_i(src), .run_i(busy), .start_i(start),
    .sck_pin_i(sck_in), .evt_o(evt), .sck_o(sck_out)
  );

  shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(start), .data_i(wr_data),
    .shift_i(shift_en), .sout_o(sout)
  );

  xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .evt_i(evt), .irq_clr_i(irq_clr),
    .busy_o(busy), .irq_o(irq), .rdy_n_o(rdy_n), .rdy_o(rdy)
  );
endmodule

// File: tb/sim_ser_tx_port.sv
module sim_ser_tx_port;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, ext_clk_sel = 1'b0, wr_valid = 1'b0, irq_clr = 1'b0, sck_in = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, irq, busy, sck_out, sout, rdy_n, rdy;

  int n_cmp = 0, n_bad = 0, cyc = 0, t_acc = 0;
  bit exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ser_tx_port #(.DATA_W(8), .CLK_DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_clk_sel(ext_clk_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .irq_clr(irq_clr), .irq(irq), .busy(busy), .sck_in(sck_in),
    .sck_out(sck_out), .sout(sout), .rdy_n(rdy_n), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_data  = d;
    wr_valid = 1'b1;
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    @(posedge clk);
    #1 wr_valid = 1'b0;
    t_acc = cyc;
  endtask

  task automatic wait_idle();
    while (busy) begin
      @(posedge clk);
      #1;
    end
    #1;
  endtask

  // monitor: internal mode, partner samples at rising shift edge
  initial begin
    forever begin
      @(posedge sck_out);
      #1;
      if (!ext_clk_sel && exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        chk(sout == e, "R4", "sout bit", int'(sout), int'(e));
      end
    end
  end

  task automatic ext_edge(input logic lvl);
    @(negedge clk);
    sck_in = lvl;
    repeat (5) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R10 reset state
    chk(busy == 0 && irq == 0, "R10", "busy/irq", int'({busy, irq}), 0);
    chk(rdy_n == 1 && rdy == 0, "R10", "rdy_n/rdy", int'({rdy_n, rdy}), 2);
    chk(sck_out == 1 && wr_ready == 1, "R10", "sck_out/wr_ready", int'({sck_out, wr_ready}), 3);

    // internal transfer A5
    send(8'hA5);
    chk(busy == 1 && rdy_n == 0 && rdy == 1, "R1", "busy,rdy_n,rdy", int'({busy, rdy_n, rdy}), 5);
    while (sck_out) begin @(posedge clk); #1; end
    chk(cyc - t_acc == DIV, "R3", "first fall delay", cyc - t_acc, DIV);
    chk(rdy_n == 1, "R5", "rdy_n at first fall", int'(rdy_n), 1);
    // R2: write offered mid-transfer is refused
    @(negedge clk);
    wr_data = 8'h3C; wr_valid = 1'b1;
    #1 chk(wr_ready == 0, "R2", "wr_ready while busy", int'(wr_ready), 0);
    repeat (2) @(posedge clk);
    #1 wr_valid = 1'b0;
    wait_idle();
    chk(cyc - t_acc == 16 * DIV, "R6", "completion cycle", cyc - t_acc, 16 * DIV);
    chk(irq == 1 && rdy == 0 && wr_ready == 1, "R6", "irq,rdy,wr_ready", int'({irq, rdy, wr_ready}), 5);
    chk(exp_q.size() == 0, "R4", "bits left", exp_q.size(), 0);
    chk(sout == 1, "R9", "sout last bit", int'(sout), 1);
    repeat (4 * DIV) @(posedge clk);
    #1;
    chk(sout == 1 && sck_out == 1, "R9", "idle sout/sck_out", int'({sout, sck_out}), 3);
    chk(irq == 1, "R7", "irq held", int'(irq), 1);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq == 0, "R7", "irq cleared", int'(irq), 0);

    // R7 completion and clear in same cycle
    send(8'h0F);
    while (cyc < t_acc + 16 * DIV - 1) begin @(posedge clk); #1; end
    irq_clr = 1'b1;
    @(posedge clk);
    #1 irq_clr = 1'b0;
    chk(irq == 1 && busy == 0, "R7", "set wins over clear", int'({irq, busy}), 2);
    #1;
    chk(exp_q.size() == 0, "R4", "bits left 0F", exp_q.size(), 0);
    chk(sout == 0, "R9", "sout last bit 0F", int'(sout), 0);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;

    // R2 tx_en low
    @(negedge clk);
    tx_en = 1'b0; wr_data = 8'hFF; wr_valid = 1'b1;
    #1 chk(wr_ready == 0, "R2", "wr_ready with tx_en=0", int'(wr_ready), 0);
    @(posedge clk);
    #1 chk(busy == 0 && rdy_n == 1, "R2", "no start", int'({busy, rdy_n}), 1);
    wr_valid = 1'b0; tx_en = 1'b1;

    // R8 external clock
    ext_clk_sel = 1'b1;
    sck_in = 1'b1;
    repeat (4) @(posedge clk);
    send(8'hD3);
    chk(rdy_n == 0 && rdy == 1, "R1", "ext rdy strobes", int'({rdy_n, rdy}), 1);
    for (int i = 0; i < 8; i++) begin
      bit e;
      ext_edge(1'b0);
      e = exp_q.pop_front();
      chk(sout == e, "R8", "ext sout bit", int'(sout), int'(e));
      if (i == 0) chk(rdy_n == 1, "R5", "ext rdy_n first fall", int'(rdy_n), 1);
      chk(busy == 1 && rdy == 1, "R8", "busy mid", int'({busy, rdy}), 3);
      ext_edge(1'b1);
    end
    chk(irq == 1 && busy == 0 && rdy == 0, "R8", "ext completion", int'({irq, busy, rdy}), 4);
    ext_edge(1'b0);
    chk(sout == 0 && busy == 0, "R8", "extra fall shifts zero", int'({sout, busy}), 0);
    ext_edge(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule